// File: doc/BRIEF.md
# Keyed Two-Write Mode Request Register

This block is a 32-bit control register through which software asks for a new operating mode. A request counts only after two full-word writes in a row. The first write carries the unlock key and the wanted mode. The second carries the same mode together with the bitwise complement of the key. When the second write completes, the block commits the mode to its stored field and raises a one-cycle request pulse for the mode sequencer downstream. If the requested code is reserved, or is masked off by the enable input, the block raises a one-cycle error pulse instead and keeps the stored field unchanged.

Two hardware inputs can overwrite the field at any time. One forces the safe mode code. The other loads one of the four run codes when the chip wakes from a low-power mode. A hardware update always wins over a software commit in the same cycle and drops any pending unlock. Reads always return the stored mode in the top nibble and the complemented key in the low half. The key itself therefore never appears on the bus.

Top module: `mode_keyreg`

## Requirements
- R1: After reset the stored mode is 4'b0011, `bus_rdata` reads 32'h3000_A50F, and `req_pulse` and `req_err` are low.
- R2: `bus_rdata[31:28]` always shows the stored mode, `bus_rdata[27:16]` is always zero, and `bus_rdata[15:0]` is always 16'hA50F.
- R3: A full write with `wdata[15:0]`=16'h5AF0 and mode M in `wdata[31:28]`, followed on the next access by a full write with 16'hA50F and the same M, updates the stored mode to M. On the clock edge that captures the second write, `req_pulse` goes high for exactly one cycle and `req_mode`=M.
- R4: A key write alone (16'h5AF0) leaves the stored mode unchanged.
- R5: A write whose byte strobes are not all four set (`bus_be`!=4'hF) has no effect. It neither arms nor commits, and it disarms a pending unlock.
- R6: A full write whose low half is neither 16'h5AF0 nor 16'hA50F is ignored and disarms a pending unlock.
- R7: An inverted-key write whose mode differs from the mode latched by the key write commits nothing and raises no error.
- R8: Any other access between the key write and the inverted-key write, including a read, cancels the unlock.
- R9: Codes 4'b1001, 4'b1011, 4'b1100 and 4'b1110 are reserved. Committing one of them raises `req_err` for one cycle, gives no `req_pulse`, and keeps the stored mode.
- R10: Bit k of `mode_en` enables mode code k. Committing a code whose enable bit is 0 raises `req_err` for one cycle and keeps the stored mode.
- R11: `hw_safe_req` loads 4'b0010 on the next edge. Otherwise `hw_wake` loads 4'b0100 + `hw_run_sel`. The safe request wins when both are high.
- R12: A hardware update in the same cycle as a valid inverted-key write wins. There is no `req_pulse` or `req_err`, the stored mode takes the hardware value, and the unlock is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register selected (address match) |
| bus_we | input | 1 | Write enable, read when low |
| bus_be | input | 4 | Byte strobes, all four needed for a write to act |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data: mode, zeros, complemented key |
| mode_en | input | 16 | Per-code enable mask |
| hw_safe_req | input | 1 | Hardware force to safe mode |
| hw_wake | input | 1 | Hardware wake event from halt or stop |
| hw_run_sel | input | 2 | Run mode index loaded on wake |
| req_pulse | output | 1 | One-cycle accepted mode request |
| req_mode | output | 4 | Mode of the last accepted request |
| req_err | output | 1 | One-cycle rejected request |

## Verification
The hardest case to reach is a correctly armed inverted-key write that lands in the very cycle a hardware update arrives. The bench holds the wake input and the second write on the same falling edge, so both are sampled by one rising edge. It then repeats the inverted-key write alone to show that the unlock really was cancelled. Every code from 0 to 15 is also committed under two enable masks, which covers reserved and masked codes against a legality table the bench computes on its own.

// File: rtl/mode_keyreg_pkg.sv
package mode_keyreg_pkg;
  localparam int DATA_W   = 32;
  localparam int MODE_W   = 4;
  localparam int KEY_W    = 16;
  localparam int STRB_W   = DATA_W / 8;
  localparam int PAD_W    = DATA_W - MODE_W - KEY_W;
  localparam int NMODES   = 1 << MODE_W;
  localparam int RUNSEL_W = 2;

  localparam logic [MODE_W-1:0] MC_SAFE = 4'b0010;
  localparam logic [MODE_W-1:0] MC_DRUN = 4'b0011;
  localparam logic [MODE_W-1:0] MC_RUN0 = 4'b0100;

  // Codes with no operating mode behind them.
  function automatic logic code_reserved(input logic [MODE_W-1:0] m);
    case (m)
      4'b1001, 4'b1011, 4'b1100, 4'b1110: code_reserved = 1'b1;
      default:                            code_reserved = 1'b0;
    endcase
  endfunction

  // Run mode code picked by a wake event.
  function automatic logic [MODE_W-1:0] run_code(input logic [RUNSEL_W-1:0] s);
    run_code = MC_RUN0 | {{(MODE_W-RUNSEL_W){1'b0}}, s};
  endfunction
endpackage

// File: rtl/keyreg_wr_decode.sv
module keyreg_wr_decode
  import mode_keyreg_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_VAL = 16'h5AF0
) (
  input  logic                 sel,
  input  logic                 we,
  input  logic [STRB_W-1:0]    be,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 key_hit,
  output logic                 inv_hit,
  output logic                 any_acc,
  output logic [MODE_W-1:0]    wr_mode
);
  localparam logic [KEY_W-1:0] INV_VAL = ~KEY_VAL;

  logic full_wr;
  assign full_wr = sel & we & (&be);
  assign any_acc = sel;
  assign wr_mode = wdata[DATA_W-1 -: MODE_W];
  assign key_hit = full_wr & (wdata[KEY_W-1:0] == KEY_VAL);
  assign inv_hit = full_wr & (wdata[KEY_W-1:0] == INV_VAL);
endmodule

// File: rtl/keyreg_legal.sv
module keyreg_legal
  import mode_keyreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [NMODES-1:0] enable,
  output logic              legal
);
  logic [NMODES-1:0] allow;

  for (genvar g = 0; g < NMODES; g++) begin : g_allow
    assign allow[g] = enable[g] & ~code_reserved(MODE_W'(g));
  end

  assign legal = allow[mode];
endmodule

// File: rtl/mode_keyreg.sv
module mode_keyreg
  import mode_keyreg_pkg::*;
#(
  parameter logic [KEY_W-1:0]  KEY_VAL    = 16'h5AF0,
  parameter logic [MODE_W-1:0] RESET_MODE = MC_DRUN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [STRB_W-1:0]   bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NMODES-1:0]   mode_en,
  input  logic                hw_safe_req,
  input  logic                hw_wake,
  input  logic [RUNSEL_W-1:0] hw_run_sel,
  output logic                req_pulse,
  output logic [MODE_W-1:0]   req_mode,
  output logic                req_err
);
  logic              key_hit, inv_hit, any_acc, legal;
  logic [MODE_W-1:0] wr_mode;
  logic [MODE_W-1:0] mode_q, cand_q, hw_mode;
  logic              armed_q, hw_any;
  logic              commit_try, commit_ok, commit_bad;

  keyreg_wr_decode #(.KEY_VAL(KEY_VAL)) u_dec (
    .sel(bus_sel), .we(bus_we), .be(bus_be), .wdata(bus_wdata),
    .key_hit(key_hit), .inv_hit(inv_hit), .any_acc(any_acc), .wr_mode(wr_mode)
  );

  keyreg_legal u_leg (
    .mode(wr_mode), .enable(mode_en), .legal(legal)
  );

  assign hw_any     = hw_safe_req | hw_wake;
  assign hw_mode    = hw_safe_req ? MC_SAFE : run_code(hw_run_sel);
  assign commit_try = inv_hit & armed_q & (wr_mode == cand_q) & ~hw_any;
  assign commit_ok  = commit_try & legal;
  assign commit_bad = commit_try & ~legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= RESET_MODE;
      cand_q    <= '0;
      armed_q   <= 1'b0;
      req_pulse <= 1'b0;
      req_err   <= 1'b0;
      req_mode  <= '0;
    end else begin
      if (hw_any)         mode_q <= hw_mode;
      else if (commit_ok) mode_q <= wr_mode;

      if (hw_any)       armed_q <= 1'b0;
      else if (key_hit) armed_q <= 1'b1;
      else if (any_acc) armed_q <= 1'b0;

      if (key_hit && !hw_any) cand_q <= wr_mode;

      req_pulse <= commit_ok;
      req_err   <= commit_bad;
      if (commit_ok) req_mode <= wr_mode;
    end
  end

  assign bus_rdata = {mode_q, {PAD_W{1'b0}}, ~KEY_VAL};

  // R3
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);
  // R3
  req_mode_matches_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> bus_rdata[DATA_W-1 -: MODE_W] == req_mode);
  // R9
  err_keeps_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($stable(mode_q) && !req_pulse));
  // R4
  arm_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(key_hit));
  // R11
  safe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_safe_req |=> bus_rdata[DATA_W-1 -: MODE_W] == MC_SAFE);
  // R12
  hw_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_any |=> (!armed_q && !req_pulse && !req_err));
endmodule

// File: tb/sim_mode_keyreg.sv
`timescale 1ns/1ps
module sim_mode_keyreg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] en = 16'hFFFF;
  logic        hsafe = 1'b0, hwake = 1'b0;
  logic [1:0]  hsel = 2'd0;
  logic        pulse, err;
  logic [3:0]  rmode;

  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_mode;

  always #2.5 clk = ~clk;

  mode_keyreg u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_be(be),
    .bus_wdata(wdata), .bus_rdata(rdata), .mode_en(en),
    .hw_safe_req(hsafe), .hw_wake(hwake), .hw_run_sel(hsel),
    .req_pulse(pulse), .req_mode(rmode), .req_err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [3:0] m, input logic [15:0] k);
    return {m, 12'h000, k};
  endfunction

  function automatic bit bench_legal(input logic [3:0] m, input logic [15:0] mask);
    bit rsv = (m == 4'd9) || (m == 4'd11) || (m == 4'd12) || (m == 4'd14);
    return !rsv && mask[m];
  endfunction

  task automatic bus_wr(input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); sel = 1; we = 1; be = b; wdata = d;
    @(negedge clk); sel = 0; we = 0; be = 0; wdata = '0;
  endtask

  task automatic bus_rd();
    @(negedge clk); sel = 1; we = 0; be = 4'hF;
    @(negedge clk); sel = 0; be = 0;
  endtask

  task automatic quiet(input string tag);
    chk({tag, " no pulse"}, {31'd0, pulse}, 32'd0);
    chk({tag, " no err"}, {31'd0, err}, 32'd0);
    chk({tag, " field"}, rdata, word(exp_mode, 16'hA50F));
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R2
    chk("R1 reset read", rdata, 32'h3000_A50F);
    chk("R1 reset pulse", {31'd0, pulse}, 32'd0);
    chk("R1 reset err", {31'd0, err}, 32'd0);
    exp_mode = 4'b0011;

    // R4 then R3
    bus_wr(word(4'd5, 16'h5AF0), 4'hF);
    quiet("R4 key only");
    bus_wr(word(4'd5, 16'hA50F), 4'hF);
    exp_mode = 4'd5;
    chk("R3 pulse", {31'd0, pulse}, 32'd1);
    chk("R3 req_mode", {28'd0, rmode}, 32'd5);
    chk("R3 field", rdata, word(4'd5, 16'hA50F));
    @(negedge clk);
    chk("R3 pulse drops", {31'd0, pulse}, 32'd0);

    // R9 R10 sweep over all codes and two masks
    for (int mi = 0; mi < 2; mi++) begin
      en = (mi == 0) ? 16'hFFFF : 16'h5A3C;
      for (int m = 0; m < 16; m++) begin
        bit ok;
        ok = bench_legal(4'(m), en);
        bus_wr(word(4'(m), 16'h5AF0), 4'hF);
        chk("R4 sweep key only", rdata, word(exp_mode, 16'hA50F));
        bus_wr(word(4'(m), 16'hA50F), 4'hF);
        if (ok) exp_mode = 4'(m);
        chk("R9 R10 pulse", {31'd0, pulse}, {31'd0, ok});
        chk("R9 R10 err", {31'd0, err}, {31'd0, !ok});
        chk("R2 R9 R10 read", rdata, word(exp_mode, 16'hA50F));
        @(negedge clk);
        chk("R9 err one cycle", {30'd0, err, pulse}, 32'd0);
      end
    end
    en = 16'hFFFF;

    // R5 partial strobes
    for (int b = 0; b < 15; b++) begin
      bus_wr(word(4'd6, 16'h5AF0), 4'(b));
      bus_wr(word(4'd6, 16'hA50F), 4'hF);
      quiet("R5 partial key");
    end
    bus_wr(word(4'd6, 16'h5AF0), 4'hF);
    bus_wr(word(4'd6, 16'hA50F), 4'h3);
    quiet("R5 partial inv");
    bus_wr(word(4'd6, 16'hA50F), 4'hF);
    quiet("R5 disarmed by partial");

    // R6 wrong key
    bus_wr(word(4'd6, 16'h5AF0), 4'hF);
    bus_wr(word(4'd6, 16'h1234), 4'hF);
    quiet("R6 bad key");
    bus_wr(word(4'd6, 16'hA50F), 4'hF);
    quiet("R6 disarmed");

    // R7 mismatched mode
    bus_wr(word(4'd4, 16'h5AF0), 4'hF);
    bus_wr(word(4'd5, 16'hA50F), 4'hF);
    quiet("R7 mode mismatch");

    // R8 intervening read
    bus_wr(word(4'd7, 16'h5AF0), 4'hF);
    bus_rd();
    bus_wr(word(4'd7, 16'hA50F), 4'hF);
    quiet("R8 read between");

    // R11 hardware updates
    @(negedge clk); hsafe = 1;
    @(negedge clk); hsafe = 0; exp_mode = 4'b0010;
    chk("R11 safe", rdata, word(exp_mode, 16'hA50F));
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); hwake = 1; hsel = 2'(s);
      @(negedge clk); hwake = 0; exp_mode = 4'(4 + s);
      chk("R11 wake run", rdata, word(exp_mode, 16'hA50F));
    end
    @(negedge clk); hwake = 1; hsafe = 1; hsel = 2'd3;
    @(negedge clk); hwake = 0; hsafe = 0; exp_mode = 4'b0010;
    chk("R11 safe beats wake", rdata, word(exp_mode, 16'hA50F));

    // R12 hardware vs commit in same cycle
    bus_wr(word(4'd7, 16'h5AF0), 4'hF);
    @(negedge clk); sel = 1; we = 1; be = 4'hF; wdata = word(4'd7, 16'hA50F);
    hwake = 1; hsel = 2'd1;
    @(negedge clk); sel = 0; we = 0; be = 0; wdata = '0; hwake = 0;
    exp_mode = 4'd5;
    quiet("R12 hw wins");
    bus_wr(word(4'd7, 16'hA50F), 4'hF);
    quiet("R12 unlock cancelled");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule